// File: doc/BRIEF.md
# Tri-Mode Dial Mode Controller

This block sits between a keypad decoder and the dialling back ends of a telephone dialler. For each validated key event it decides three things: whether the key is sent as loop-disconnect pulses or as a DTMF tone pair, whether it is written into the redial memory, and whether it is a function key. It also holds the one bit of state that mixed operation needs, the latch that moves the dialler from pulse to tone signalling. Key scanning, tone generation, pulse timing and the digit store are handled by neighbouring blocks that act on the strobes produced here.

A two-bit select input models the three-level mode pin: pulse, DTMF, or mixed. In mixed operation the dialler starts in pulse signalling. It moves to DTMF when the user presses a symbol key or a dedicated shift key, and it stays there until a flash or a chip-enable cycle. All strobes are registered. Each one is high for exactly the cycle after the clock edge that samples the key strobe, and it is computed from the mode as it stands after that same edge.

Top module: `dial_route_ctrl`

## Requirements
- R1: The select input `dial_sel` uses this encoding: 2'b00 means pulse, 2'b01 means DTMF, and 2'b10 or 2'b11 means mixed. The output `dtmf_mode` is high when the select is DTMF, or when the select is mixed and the mixed latch is set.
- R2: Key codes are these: 0 to 9 are the digits; 10 to 15 are the symbol keys A, B, C, D, * and #; 16 is program; 17 is flash; 18 is redial; 19 is the shift key. Any code of 20 or more causes no strobe and does not change the mode.
- R3: When the block is not in DTMF, a digit key gives `pulse_stb` and `store_stb`. A symbol key gives no strobe and no mode change while the select is pulse. The shift key is also ignored while the select is pulse.
- R4: While the select is DTMF, every digit and every symbol key gives `tone_stb` and `store_stb`. The shift key gives no strobe.
- R5: Program, flash and redial give `prog_stb`, `flash_stb` and `redial_stb` in every mode. None of them gives `store_stb`.
- R6: In mixed mode the latch is clear after reset, after a flash key, and after chip enable has been low. A digit pressed in that state is dialled as pulses.
- R7: In mixed mode a symbol key sets the latch. That same key is sent with `tone_stb` and `store_stb`, and every later digit is also sent as tones.
- R8: In mixed mode the shift key sets the latch and produces no strobe.
- R9: The select sets and clears the latch. Any cycle with the select at pulse clears it, so mixed mode then resumes in pulse. Any cycle with the select at DTMF sets it, so mixed mode then continues in DTMF.
- R10: While `chip_en` is low, key strobes are ignored and no output strobe is raised.
- R11: Every strobe is high for exactly the one cycle after the clock edge that sampled `key_stb`. At most one of `pulse_stb`, `tone_stb`, `prog_stb`, `flash_stb` and `redial_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable. Low means standby. |
| dial_sel | input | 2 | Dial mode select: 00 pulse, 01 DTMF, 1x mixed |
| key_stb | input | 1 | Key event valid for one cycle |
| key_code | input | KEY_W | Decoded key code |
| dtmf_mode | output | 1 | Current signalling is DTMF |
| store_stb | output | 1 | Write the digit into redial memory |
| pulse_stb | output | 1 | Send the digit as pulses |
| tone_stb | output | 1 | Send the key as a tone pair |
| prog_stb | output | 1 | Program key pressed |
| flash_stb | output | 1 | Flash key pressed |
| redial_stb | output | 1 | Redial key pressed |

## Verification
The bench builds the block with the default KEY_W of 5. With that width the whole code space is 32 values, so every code can be swept. The sweep covers all four select values. It runs each one twice, once with the mixed latch cleared by a flash and once with the latch set by the shift key, so every key class meets every mode and latch state. Directed sequences then cover the standby gating, the resume-in-pulse behaviour after chip enable, and the select transitions that set or clear the latch.

// File: rtl/dial_route_pkg.sv
package dial_route_pkg;

   localparam int CODE_W = 5;

   localparam logic [CODE_W-1:0] K_DIGIT_MAX = 5'd9;
   localparam logic [CODE_W-1:0] K_SYM_MIN   = 5'd10;
   localparam logic [CODE_W-1:0] K_SYM_MAX   = 5'd15;
   localparam logic [CODE_W-1:0] K_PROG      = 5'd16;
   localparam logic [CODE_W-1:0] K_FLASH     = 5'd17;
   localparam logic [CODE_W-1:0] K_REDIAL    = 5'd18;
   localparam logic [CODE_W-1:0] K_SHIFT     = 5'd19;

   typedef enum logic [1:0] {
      SEL_PULSE = 2'b00,
      SEL_TONE  = 2'b01,
      SEL_MIX   = 2'b10,
      SEL_MIX2  = 2'b11
   } dial_sel_e;

   typedef struct packed {
      logic is_digit;
      logic is_sym;
      logic is_prog;
      logic is_flash;
      logic is_redial;
      logic is_shift;
   } key_class_t;

endpackage

// File: rtl/key_classifier.sv
module key_classifier
   import dial_route_pkg::*;
#(
   parameter int KEY_W = 5
) (
   input  logic [KEY_W-1:0] key_code,
   output key_class_t       cls
);
   logic             hi_clear;
   logic [CODE_W-1:0] low;

   assign low = key_code[CODE_W-1:0];

   generate
      if (KEY_W > CODE_W) begin : g_wide
         assign hi_clear = ~|key_code[KEY_W-1:CODE_W];
      end else begin : g_exact
         assign hi_clear = 1'b1;
      end
   endgenerate

   always_comb begin
      cls           = '0;
      cls.is_digit  = hi_clear && (low <= K_DIGIT_MAX);
      cls.is_sym    = hi_clear && (low >= K_SYM_MIN) && (low <= K_SYM_MAX);
      cls.is_prog   = hi_clear && (low == K_PROG);
      cls.is_flash  = hi_clear && (low == K_FLASH);
      cls.is_redial = hi_clear && (low == K_REDIAL);
      cls.is_shift  = hi_clear && (low == K_SHIFT);
   end
endmodule

// File: rtl/mode_latch.sv
module mode_latch
   import dial_route_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chip_en,
   input  logic [1:0] dial_sel,
   input  logic       fire,
   input  key_class_t cls,
   output logic       lat_q,
   output logic       lat_d
);
   always_comb begin
      lat_d = lat_q;
      if (!chip_en) begin
         lat_d = 1'b0;
      end else begin
         case (dial_sel)
            SEL_PULSE: lat_d = 1'b0;
            SEL_TONE:  lat_d = 1'b1;
            default: begin
               if (fire && (cls.is_sym || cls.is_shift)) lat_d = 1'b1;
               else if (fire && cls.is_flash)            lat_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= lat_d;
   end
endmodule

// File: rtl/route_stage.sv
module route_stage
   import dial_route_pkg::*;
#(
   parameter int N_STB = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             tone_now,
   input  key_class_t       cls,
   output logic [N_STB-1:0] stb_q
);
   logic [N_STB-1:0] stb_d;
   logic             dial_key;

   assign dial_key = cls.is_digit || (cls.is_sym && tone_now);

   always_comb begin
      stb_d    = '0;
      stb_d[0] = fire && dial_key;
      stb_d[1] = fire && cls.is_digit && !tone_now;
      stb_d[2] = fire && dial_key && tone_now;
      stb_d[3] = fire && cls.is_prog;
      stb_d[4] = fire && cls.is_flash;
      stb_d[5] = fire && cls.is_redial;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= '0;
      else        stb_q <= stb_d;
   end
endmodule

// File: rtl/dial_route_ctrl.sv
module dial_route_ctrl
   import dial_route_pkg::*;
#(
   parameter int KEY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic [1:0]       dial_sel,
   input  logic             key_stb,
   input  logic [KEY_W-1:0] key_code,
   output logic             dtmf_mode,
   output logic             store_stb,
   output logic             pulse_stb,
   output logic             tone_stb,
   output logic             prog_stb,
   output logic             flash_stb,
   output logic             redial_stb
);
   localparam int N_STB = 6;

   generate
      if (KEY_W < CODE_W) begin : g_bad_width
         $error("dial_route_ctrl: KEY_W must be at least %0d", CODE_W);
      end
   endgenerate

   key_class_t       cls;
   logic             fire;
   logic             lat_q;
   logic             lat_d;
   logic             tone_now;
   logic [N_STB-1:0] stb_q;

   assign fire = key_stb && chip_en;

   key_classifier #(.KEY_W(KEY_W)) u_cls (
      .key_code (key_code),
      .cls      (cls)
   );

   mode_latch u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .chip_en  (chip_en),
      .dial_sel (dial_sel),
      .fire     (fire),
      .cls      (cls),
      .lat_q    (lat_q),
      .lat_d    (lat_d)
   );

   assign tone_now = (dial_sel == SEL_TONE) || (dial_sel[1] && lat_d);

   route_stage #(.N_STB(N_STB)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .tone_now (tone_now),
      .cls      (cls),
      .stb_q    (stb_q)
   );

   assign dtmf_mode  = (dial_sel == SEL_TONE) || (dial_sel[1] && lat_q);
   assign store_stb  = stb_q[0];
   assign pulse_stb  = stb_q[1];
   assign tone_stb   = stb_q[2];
   assign prog_stb   = stb_q[3];
   assign flash_stb  = stb_q[4];
   assign redial_stb = stb_q[5];
endmodule

// File: rtl/dial_route_chk.sv
module dial_route_chk #(
   parameter int KEY_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chip_en,
   input logic [1:0]       dial_sel,
   input logic             key_stb,
   input logic [KEY_W-1:0] key_code,
   input logic             dtmf_mode,
   input logic             store_stb,
   input logic             pulse_stb,
   input logic             tone_stb,
   input logic             prog_stb,
   input logic             flash_stb,
   input logic             redial_stb
);
   logic any_stb;
   assign any_stb = store_stb | pulse_stb | tone_stb | prog_stb | flash_stb | redial_stb;

   assert_onehot_route_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pulse_stb, tone_stb, prog_stb, flash_stb, redial_stb}));

   assert_no_stb_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(key_stb)) |-> !any_stb);

   assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(chip_en)) |-> !any_stb);

   assert_unused_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(key_code) >= KEY_W'(20))) |-> !any_stb);

   assert_pulse_no_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dial_sel) == 2'b00) |-> !tone_stb);

   assert_tone_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dial_sel) == 2'b01) |-> !pulse_stb);

   assert_tone_stores_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tone_stb |-> store_stb);

   assert_reenable_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(chip_en) && dial_sel[1]) |-> !dtmf_mode);

   assert_sel_low_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dial_sel) == 2'b00 && dial_sel[1]) |-> !dtmf_mode);

   assert_sel_high_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(chip_en) && $past(dial_sel) == 2'b01 && dial_sel[1])
      |-> dtmf_mode);
endmodule

bind dial_route_ctrl dial_route_chk #(.KEY_W(KEY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_en    (chip_en),
   .dial_sel   (dial_sel),
   .key_stb    (key_stb),
   .key_code   (key_code),
   .dtmf_mode  (dtmf_mode),
   .store_stb  (store_stb),
   .pulse_stb  (pulse_stb),
   .tone_stb   (tone_stb),
   .prog_stb   (prog_stb),
   .flash_stb  (flash_stb),
   .redial_stb (redial_stb)
);

// File: tb/tb_dial_route_ctrl.sv
module tb_dial_route_ctrl;
   localparam int KW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          chip_en;
   logic [1:0]    dial_sel;
   logic          key_stb;
   logic [KW-1:0] key_code;
   logic dtmf_mode, store_stb, pulse_stb, tone_stb, prog_stb, flash_stb, redial_stb;

   int  total = 0;
   int  bad   = 0;
   int  cyc   = 0;
   bit  lat_m = 1'b0;

   always #2 clk = ~clk;

   dial_route_ctrl #(.KEY_W(KW)) dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .dial_sel(dial_sel),
      .key_stb(key_stb), .key_code(key_code), .dtmf_mode(dtmf_mode),
      .store_stb(store_stb), .pulse_stb(pulse_stb), .tone_stb(tone_stb),
      .prog_stb(prog_stb), .flash_stb(flash_stb), .redial_stb(redial_stb)
   );

   // observed vector: {dtmf_mode, store, pulse, tone, prog, flash, redial}
   function automatic logic [6:0] obs();
      return {dtmf_mode, store_stb, pulse_stb, tone_stb, prog_stb, flash_stb, redial_stb};
   endfunction

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%b exp=%b (dtmf,store,pulse,tone,prog,flash,redial)", req, act, exp);
      end
   endtask

   task automatic set_sel(input int s);
      @(negedge clk) dial_sel = 2'(s);
      @(negedge clk);
      if (s == 0) lat_m = 1'b0;
      else if (s == 1) lat_m = 1'b1;
   endtask

   // spec model of one accepted key with chip enable high
   task automatic expect_key(input int s, input int c, output logic [6:0] e, output string req);
      bit dm;
      e = '0;
      if (s == 0) lat_m = 1'b0;
      else if (s == 1) lat_m = 1'b1;
      else if ((c >= 10 && c <= 15) || c == 19) lat_m = 1'b1;
      else if (c == 17) lat_m = 1'b0;
      dm = (s == 1) || (s >= 2 && lat_m);
      e[6] = dm;
      if (c <= 9) begin
         e[5] = 1'b1; e[4] = !dm; e[3] = dm;
         req = dm ? "R4/R7 digit tone" : "R3/R6 digit pulse";
      end else if (c <= 15) begin
         e[5] = dm; e[3] = dm;
         req = (s == 0) ? "R3 symbol ignored" : (s == 1) ? "R4 symbol tone" : "R7 symbol switch";
      end else if (c == 16) begin e[2] = 1'b1; req = "R5 program"; end
      else if (c == 17) begin e[1] = 1'b1; req = "R5/R6 flash"; end
      else if (c == 18) begin e[0] = 1'b1; req = "R5 redial"; end
      else if (c == 19) req = (s >= 2) ? "R8 shift" : "R3/R4 shift ignored";
      else req = "R2 unused code";
   endtask

   task automatic press(input int c);
      @(negedge clk) begin key_stb = 1'b1; key_code = KW'(c); end
      @(negedge clk) key_stb = 1'b0;
   endtask

   task automatic press_chk(input int c);
      logic [6:0] e;
      string      req;
      press(c);
      expect_key(int'(dial_sel), c, e, req);
      chk($sformatf("%s code=%0d sel=%0d", req, c, dial_sel), obs(), e);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; chip_en = 1'b1; dial_sel = 2'b10; key_stb = 1'b0; key_code = '0;
      repeat (3) @(negedge clk);
      chk("R6/R11 reset state", obs(), 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 mixed starts pulse", obs(), 7'b0);

      // sweep all selects, both latch states, all codes
      for (int s = 0; s < 4; s++) begin
         set_sel(s);
         for (int pre = 0; pre < 2; pre++) begin
            press_chk(17);
            if (pre == 1) press_chk(19);
            for (int c = 0; c < 32; c++) begin
               press_chk(c);
               if (s >= 2) begin
                  press_chk(17);
                  if (pre == 1) press_chk(19);
               end
            end
         end
         @(negedge clk);
         chk("R11 strobes single cycle", obs() & 7'b0111111, 7'b0);
      end

      // directed mixed sequence
      set_sel(2);
      press_chk(17);
      press(5);  chk("R6 digit after flash pulses", obs(), 7'b0110000);
      press(11); chk("R7 symbol key itself as tone", obs(), 7'b1101000);
      press(3);  chk("R7 later digit as tone", obs(), 7'b1101000);
      @(negedge clk) chip_en = 1'b0;
      press(4);  chk("R10 key ignored in standby", obs(), 7'b0);
      @(negedge clk) chip_en = 1'b1;
      @(negedge clk);
      lat_m = 1'b0;
      chk("R6 re-enable resumes pulse", obs(), 7'b0);
      press(3);  chk("R6 digit after re-enable pulses", obs(), 7'b0110000);
      press(19); chk("R8 shift gives no strobe, sets DTMF", obs(), 7'b1000000);
      press(0);  chk("R8 numeric first tone digit", obs(), 7'b1101000);
      set_sel(0); set_sel(2);
      chk("R9 select low clears latch", obs(), 7'b0);
      set_sel(1); set_sel(3);
      chk("R9 select high sets latch", obs(), 7'b1000000);
      press(7);  chk("R9/R1 mixed after high keeps tone", obs(), 7'b1101000);
      set_sel(0);
      press(12); chk("R3 symbol in pulse has no effect", obs(), 7'b0);
      set_sel(2);
      chk("R3 symbol in pulse left mode unchanged", obs(), 7'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule